// File: doc/BRIEF.md
# Setup Command Capture Buffer

This block holds the eight-byte command that arrives in the setup stage of a control transfer, for firmware to read. The bus engine pushes the command one byte per cycle. With the first byte it states whether the command is one that hardware answers by itself. Such commands are dropped. Only commands meant for firmware are written into the buffer. Each new firmware command replaces the stored bytes at once, whatever the CPU is doing at that moment.

The CPU reads through a single byte window. Each read strobe advances an internal position that wraps after the last byte. A flag shows that a full command has landed, and software clears it with a one-cycle strobe. A sticky invalid flag tells software that the bytes it has collected may mix two different commands. The read position is never realigned by hardware. If software abandons a pass partway, its next pass starts from the wrong byte.

Top module: `setup_cmd_capture`

## Requirements
- R1: After reset the read position is 0, both flags are low and every stored byte reads as 0x00.
- R2: The eight bytes of a firmware stage are stored at positions 0 to 7 in arrival order. With no write and no read, the byte window does not change.
- R3: setupRcvd rises in the cycle after the eighth byte of a firmware stage and stays high until a clrRcvd strobe. If the strobe arrives in the same cycle as that eighth byte, the flag is set.
- R4: A stage whose first byte carries usbAuto high stores nothing and leaves both flags unchanged. Its eight byte slots are still counted, so the following stage starts cleanly.
- R5: cpuRdData shows the byte at the current read position without delay. Each cpuRdEn advances the position by one, and the position wraps from 7 to 0.
- R6: A firmware stage overwrites the stored command unconditionally, including when a read pass is partway done.
- R7: rdInvalid is set when the first byte of a firmware stage arrives while the read position is not 0.
- R8: rdInvalid is set when cpuRdEn is asserted while a firmware stage is being stored, including the cycle of its first byte.
- R9: rdInvalid clears on a cpuRdEn at position 0 while no firmware stage is being stored. A set condition in the same cycle wins.
- R10: A new setup stage does not move the read position, so a pass abandoned after k bytes makes the next pass begin at byte k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| usbWrEn | input | 1 | One setup byte is presented this cycle |
| usbWrData | input | DATA_W | Setup byte |
| usbAuto | input | 1 | Sampled with the first byte of a stage: high means hardware handles the command |
| cpuRdEn | input | 1 | CPU reads the current byte and advances the position |
| cpuRdData | output | DATA_W | Byte at the current read position |
| rdPos | output | IDX_W | Current read position |
| setupRcvd | output | 1 | A complete firmware command has been stored |
| clrRcvd | input | 1 | Clears setupRcvd |
| rdInvalid | output | 1 | Sticky: the bytes read in the current pass may not form one command |

## Verification
An error in the write counter shows on the very next stage. Bytes land at rotated positions, or setupRcvd rises a cycle early or late, and the following read pass exposes either fault byte by byte. An error in the read position shows on the next read, as a wrong byte on cpuRdData. An error in the invalid logic shows one cycle after the read or stage start that should have set or cleared rdInvalid. The bench therefore sweeps every abandon depth and every collision offset between a read and a stage.

// File: rtl/scc_pkg.sv
package scc_pkg;
  typedef struct packed {
    logic store;
  } dpStrobe_t;
endpackage

// File: rtl/scc_ctrl.sv
module scc_ctrl
  import scc_pkg::*;
#(
  parameter int CMD_BYTES = 8,
  localparam int IDX_W = $clog2(CMD_BYTES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             usbWrEn,
  input  logic             usbAuto,
  input  logic             cpuRdEn,
  input  logic             clrRcvd,
  output dpStrobe_t        dpStb,
  output logic [IDX_W-1:0] wrIdx,
  output logic [IDX_W-1:0] rdIdx,
  output logic             rcvd,
  output logic             invalid
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(CMD_BYTES - 1);

  logic stageFw;
  logic wrStart;
  logic fwNow;
  logic store;
  logic capActive;
  logic invSet;
  logic invClr;

  assign wrStart   = usbWrEn && (wrIdx == '0);
  assign fwNow     = wrStart ? !usbAuto : stageFw;
  assign store     = usbWrEn && fwNow;
  assign capActive = store || ((wrIdx != '0) && stageFw);
  assign invSet    = (store && wrStart && (rdIdx != '0)) || (cpuRdEn && capActive);
  assign invClr    = cpuRdEn && (rdIdx == '0) && !capActive;

  assign dpStb.store = store;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrIdx   <= '0;
      stageFw <= 1'b0;
    end else if (usbWrEn) begin
      wrIdx <= (wrIdx == LAST) ? '0 : wrIdx + 1'b1;
      if (wrStart) stageFw <= !usbAuto;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdIdx <= '0;
    else if (cpuRdEn) rdIdx <= (rdIdx == LAST) ? '0 : rdIdx + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rcvd <= 1'b0;
    else if (store && (wrIdx == LAST)) rcvd <= 1'b1;
    else if (clrRcvd) rcvd <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) invalid <= 1'b0;
    else if (invSet) invalid <= 1'b1;
    else if (invClr) invalid <= 1'b0;
  end
endmodule

// File: rtl/scc_datapath.sv
module scc_datapath
  import scc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CMD_BYTES = 8,
  localparam int IDX_W = $clog2(CMD_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         dpStb,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic [IDX_W-1:0]  rdIdx,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);
  logic [DATA_W-1:0] cmdMem [CMD_BYTES];

  for (genvar b = 0; b < CMD_BYTES; b++) begin : g_byte
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) cmdMem[b] <= '0;
      else if (dpStb.store && (wrIdx == IDX_W'(b))) cmdMem[b] <= wrData;
    end
  end

  assign rdData = cmdMem[rdIdx];
endmodule

// File: rtl/setup_cmd_capture.sv
module setup_cmd_capture
  import scc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CMD_BYTES = 8,
  localparam int IDX_W = $clog2(CMD_BYTES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              usbWrEn,
  input  logic [DATA_W-1:0] usbWrData,
  input  logic              usbAuto,
  input  logic              cpuRdEn,
  output logic [DATA_W-1:0] cpuRdData,
  output logic [IDX_W-1:0]  rdPos,
  output logic              setupRcvd,
  input  logic              clrRcvd,
  output logic              rdInvalid
);
  dpStrobe_t        dpStb;
  logic [IDX_W-1:0] capWrIdx;

  scc_ctrl #(.CMD_BYTES(CMD_BYTES)) u_ctrl (
    .clk(clk), .rstN(rstN), .usbWrEn(usbWrEn), .usbAuto(usbAuto),
    .cpuRdEn(cpuRdEn), .clrRcvd(clrRcvd), .dpStb(dpStb), .wrIdx(capWrIdx),
    .rdIdx(rdPos), .rcvd(setupRcvd), .invalid(rdInvalid)
  );

  scc_datapath #(.DATA_W(DATA_W), .CMD_BYTES(CMD_BYTES)) u_dp (
    .clk(clk), .rstN(rstN), .dpStb(dpStb), .wrIdx(capWrIdx), .rdIdx(rdPos),
    .wrData(usbWrData), .rdData(cpuRdData)
  );
endmodule

// File: rtl/scc_checker.sv
module scc_checker #(
  parameter int DATA_W = 8,
  parameter int CMD_BYTES = 8,
  localparam int IDX_W = $clog2(CMD_BYTES)
) (
  input logic              clk,
  input logic              rstN,
  input logic              usbWrEn,
  input logic              usbAuto,
  input logic              cpuRdEn,
  input logic              clrRcvd,
  input logic [DATA_W-1:0] cpuRdData,
  input logic [IDX_W-1:0]  rdPos,
  input logic [IDX_W-1:0]  capWrIdx,
  input logic              setupRcvd,
  input logic              rdInvalid
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(CMD_BYTES - 1);

  assert_window_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (!usbWrEn && !cpuRdEn) |=> $stable(cpuRdData));

  assert_rcvd_clear_R3: assert property (@(posedge clk) disable iff (!rstN)
    (clrRcvd && !usbWrEn) |=> !setupRcvd);

  assert_auto_no_effect_R4: assert property (@(posedge clk) disable iff (!rstN)
    (usbWrEn && usbAuto && capWrIdx == '0 && !clrRcvd && !cpuRdEn)
    |=> ($stable(setupRcvd) && $stable(rdInvalid)));

  assert_pos_advance_R5: assert property (@(posedge clk) disable iff (!rstN)
    cpuRdEn |=> rdPos == (($past(rdPos) == LAST) ? '0 : $past(rdPos) + 1'b1));

  assert_start_mid_read_R7: assert property (@(posedge clk) disable iff (!rstN)
    (usbWrEn && !usbAuto && capWrIdx == '0 && rdPos != '0) |=> rdInvalid);

  assert_read_at_start_R8: assert property (@(posedge clk) disable iff (!rstN)
    (usbWrEn && !usbAuto && capWrIdx == '0 && cpuRdEn) |=> rdInvalid);

  assert_pos_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !cpuRdEn |=> $stable(rdPos));
endmodule

bind setup_cmd_capture scc_checker #(.DATA_W(DATA_W), .CMD_BYTES(CMD_BYTES)) u_chk (
  .clk(clk), .rstN(rstN), .usbWrEn(usbWrEn), .usbAuto(usbAuto), .cpuRdEn(cpuRdEn),
  .clrRcvd(clrRcvd), .cpuRdData(cpuRdData), .rdPos(rdPos), .capWrIdx(capWrIdx),
  .setupRcvd(setupRcvd), .rdInvalid(rdInvalid)
);

// File: tb/test_setup_cmd_capture.sv
module test_setup_cmd_capture;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       usbWrEn = 1'b0;
  logic [7:0] usbWrData = '0;
  logic       usbAuto = 1'b0;
  logic       cpuRdEn = 1'b0;
  logic       clrRcvd = 1'b0;
  logic [7:0] cpuRdData;
  logic [2:0] rdPos;
  logic       setupRcvd;
  logic       rdInvalid;

  int nRun = 0;
  int nFail = 0;
  logic [7:0] expMem [8];
  int expPos = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  setup_cmd_capture i_setup_cmd_capture (
    .clk(clk), .rstN(rstN), .usbWrEn(usbWrEn), .usbWrData(usbWrData),
    .usbAuto(usbAuto), .cpuRdEn(cpuRdEn), .cpuRdData(cpuRdData), .rdPos(rdPos),
    .setupRcvd(setupRcvd), .clrRcvd(clrRcvd), .rdInvalid(rdInvalid)
  );

  function automatic logic [7:0] pat(input logic [7:0] base, input int k);
    return base ^ 8'(k * 37);
  endfunction

  task automatic check(input string req, input int act, input int exp);
    nRun++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // rdAt: byte slot at which cpuRdEn is pulsed (8 = never); clrLast: clrRcvd on the 8th byte
  task automatic writeStage(input logic auto, input logic [7:0] base, input int rdAt,
                            input logic clrLast);
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      usbWrEn   = 1'b1;
      usbAuto   = (k == 0) ? auto : 1'b0;
      usbWrData = pat(base, k);
      cpuRdEn   = (k == rdAt);
      clrRcvd   = clrLast && (k == 7);
      if (!auto) expMem[k] = pat(base, k);
      if (k == rdAt) expPos = (expPos + 1) % 8;
    end
    @(negedge clk);
    usbWrEn = 1'b0;
    cpuRdEn = 1'b0;
    clrRcvd = 1'b0;
  endtask

  task automatic readByte(input string req);
    @(negedge clk);
    check(req, cpuRdData, expMem[expPos]);
    cpuRdEn = 1'b1;
    @(negedge clk);
    cpuRdEn = 1'b0;
    expPos = (expPos + 1) % 8;
  endtask

  task automatic clearRcvd;
    @(negedge clk);
    clrRcvd = 1'b1;
    @(negedge clk);
    clrRcvd = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    nRun++;
    nFail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    for (int k = 0; k < 8; k++) expMem[k] = 8'h00;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 pos", rdPos, 0);
    check("R1 rcvd", setupRcvd, 0);
    check("R1 invalid", rdInvalid, 0);
    rstN = 1'b1;
    for (int k = 0; k < 8; k++) readByte("R1 data");

    // R2 R3 R5: firmware capture, flag, ordered read with wrap
    writeStage(1'b0, 8'h10, 8, 1'b0);
    check("R3 rcvd set", setupRcvd, 1);
    check("R2 invalid idle", rdInvalid, 0);
    for (int k = 0; k < 8; k++) readByte("R2 R5 data");
    @(negedge clk);
    check("R5 wrap", rdPos, 0);
    check("R9 stays clear", rdInvalid, 0);
    clearRcvd();
    check("R3 rcvd cleared", setupRcvd, 0);

    // R4: hardware-handled stage during a partial pass
    for (int k = 0; k < 3; k++) readByte("R4 pre");
    writeStage(1'b1, 8'h80, 8, 1'b0);
    check("R4 rcvd unchanged", setupRcvd, 0);
    check("R4 invalid unchanged", rdInvalid, 0);
    check("R4 pos", rdPos, 3);
    for (int k = 0; k < 5; k++) readByte("R4 old data kept");

    // R3: clear and set in the same cycle, set wins
    writeStage(1'b0, 8'h22, 8, 1'b1);
    check("R3 set wins", setupRcvd, 1);
    clearRcvd();

    // R6 R7 R9 R10: sweep of every abandon depth
    for (int a = 0; a < 8; a++) begin
      for (int k = 0; k < a; k++) readByte("R10 partial");
      writeStage(1'b0, 8'(a * 29 + 101), 8, 1'b0);
      check("R7 invalid on stage start", rdInvalid, (a != 0) ? 1 : 0);
      check("R10 pos kept", rdPos, a);
      check("R3 rcvd", setupRcvd, 1);
      clearRcvd();
      for (int k = 0; k < 8; k++) readByte("R6 R10 overwritten data");
      @(negedge clk);
      check("R9 cleared by read at 0", rdInvalid, 0);
      for (int k = 0; k < (8 - a) % 8; k++) readByte("R10 realign");
    end

    // R8 R9: read colliding with each byte slot of a stage
    for (int s = 0; s < 8; s++) begin
      writeStage(1'b0, 8'(s * 53 + 7), s, 1'b0);
      check("R8 invalid on read during capture", rdInvalid, 1);
      check("R8 pos", rdPos, 1);
      for (int k = 0; k < 7; k++) readByte("R8 data");
      @(negedge clk);
      check("R9 still set", rdInvalid, 1);
      readByte("R9 clearing read");
      @(negedge clk);
      check("R9 clear", rdInvalid, 0);
      for (int k = 0; k < 7; k++) readByte("R9 realign");
      clearRcvd();
    end

    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule